// File: doc/BRIEF.md
# SDRAM Command Rule Checker

A passive observer for the command bus of a single-data-rate SDRAM with a power-of-two number of banks (four by default). Each cycle it decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command. It keeps, for every bank, whether a row is open and how many cycles remain in each of that bank's spacing windows. A handful of global windows are kept as well. Any command that breaks an ordering or spacing rule is reported.

Reporting has two parts. A combinational pulse and an encoded rule number appear in the same cycle as the offending command. A vector of sticky flags, one per rule, records every rule broken since the last clear. All spacing limits are parameters, given in clock cycles. The block is meant to sit beside a memory controller, either in simulation or in a prototype, as an assertion engine that can be synthesized.

A flagged command still updates the tracked bank state as if the memory had accepted it. Later checks therefore follow what the device would really do.

Top module: `sdram_rule_checker`

## Requirements
- R1: The command is decoded from {cs_n,ras_n,cas_n,we_n}. 1xxx (deselect) and 0111 are no-operations. 0011 is activate, 0101 is read, 0100 is write, 0010 is precharge, 0001 is auto refresh, 0000 is mode set and 0110 is burst stop. A no-operation never raises a violation.
- R2: A bank-select value i addresses bank i. A precharge with a10=1 closes every open bank. A read or write with a10=1 requests auto precharge and closes its bank. Flagged commands still update bank state.
- R3: A mode set or auto refresh issued while any bank is open violates rule 1.
- R4: Any command other than a no-operation, issued fewer than T_MRD cycles after a mode set, violates rule 0.
- R5: A read or write issued fewer than BURST_LEN cycles after a read or write with auto precharge violates rule 2. An activate violates rule 3 if it comes too soon after its bank was closed. The minimum spacing is T_RP after an explicit precharge, BURST_LEN+T_RP after a read with auto precharge, and BURST_LEN-1+T_WR+T_RP after a write with auto precharge.
- R6: An activate issued fewer than T_RRD cycles after the previous activate violates rule 4.
- R7: A read or write to an open bank issued fewer than T_RCD cycles after that bank's activate violates rule 5. Column commands on consecutive cycles are otherwise legal.
- R8: A precharge that closes an open bank violates rule 6 if it comes fewer than T_RAS cycles after that bank's activate. It violates rule 7 if it comes fewer than BURST_LEN-1+T_WR cycles after a write to that bank.
- R9: A read, a write, or a single-bank precharge (a10=0) to an idle bank violates rule 8. A precharge with a10=1 never does.
- R10: An activate to a bank that is already open violates rule 9.
- R11: Bit k of viol_flags_o is set at the clock edge that ends a cycle in which rule k is violated. It stays set until clr_i is high at an edge, which clears it. A violation in the clearing cycle sets its bit anyway.
- R12: err_pulse_o is high during exactly the cycles that contain a violation. In those cycles err_id_o equals k+1, where k is the lowest violated rule number. Otherwise err_id_o is 0.
- R13: A command in a cycle where mem_cke was low at the previous clock edge is ignored, and all spacing windows hold their count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_cke | input | 1 | Clock enable seen on the bus |
| mem_cs_n | input | 1 | Chip select, active low |
| mem_ras_n | input | 1 | Row strobe, active low |
| mem_cas_n | input | 1 | Column strobe, active low |
| mem_we_n | input | 1 | Write enable, active low |
| mem_ba | input | BA_W | Bank select |
| mem_a10 | input | 1 | Auto-precharge / all-bank select bit |
| clr_i | input | 1 | Synchronous clear of the sticky flags |
| viol_flags_o | output | 10 | Sticky per-rule violation flags |
| err_pulse_o | output | 1 | High in a cycle holding a violation |
| err_id_o | output | 4 | Lowest violated rule number plus one, 0 when none |

## Verification
The bench builds the checker with BURST_LEN=2, T_RCD=2, T_RP=3, T_RAS=4, T_RRD=2, T_WR=2 and T_MRD=2. These short windows put every spacing boundary, on both the legal and the violating side, within a few commands. The limits also differ from one another, so a window fed from the wrong timer, or off by one cycle, changes an expected rule number. The auto-precharge recovery window is five cycles, which lets the same sequence probe the burst collision and the later reactivation.

// File: rtl/sdrc_pkg.sv
package sdrc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_REF,
    CMD_MRS,
    CMD_BST
  } sdrc_cmd_e;

  localparam int unsigned RULE_CNT  = 10;
  localparam int unsigned RULE_ID_W = $clog2(RULE_CNT + 1);

  // Rule numbers; a lower number wins the encoded report.
  localparam int unsigned RULE_MRD      = 0;
  localparam int unsigned RULE_OPENBUSY = 1;
  localparam int unsigned RULE_APBURST  = 2;
  localparam int unsigned RULE_RP       = 3;
  localparam int unsigned RULE_RRD      = 4;
  localparam int unsigned RULE_RCD      = 5;
  localparam int unsigned RULE_RAS      = 6;
  localparam int unsigned RULE_WR       = 7;
  localparam int unsigned RULE_IDLE     = 8;
  localparam int unsigned RULE_REOPEN   = 9;

endpackage

// File: rtl/sdrc_gap_timer.sv
module sdrc_gap_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (adv) begin
      if (load) begin
        cnt_d = load_val;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (cnt_q != '0);

  // R5..R8 windows: a load opens a window exactly when its value is non-zero
  a_r5_window_load: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && load) |=> (busy == ($past(load_val) != '0)));

  // R13: a frozen window holds its state
  a_r13_window_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv) |=> $stable(busy));

endmodule

// File: rtl/sdrc_decode.sv
module sdrc_decode
  import sdrc_pkg::*;
(
  input  logic      adv,
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output sdrc_cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (adv && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdrc_bank.sv
module sdrc_bank
  import sdrc_pkg::*;
#(
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_WR      = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  logic      hit,
  input  logic      a10,
  input  sdrc_cmd_e cmd,
  output logic      open_o,
  output logic      rcd_busy_o,
  output logic      ras_busy_o,
  output logic      rp_busy_o,
  output logic      wr_busy_o,
  output logic      ap_busy_o
);

  localparam logic [CNT_W-1:0] LD_RCD   = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] LD_RAS   = CNT_W'(T_RAS - 1);
  localparam logic [CNT_W-1:0] LD_RP    = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] LD_RDAP  = CNT_W'(BURST_LEN + T_RP - 1);
  localparam logic [CNT_W-1:0] LD_WRAP  = CNT_W'(BURST_LEN + T_WR + T_RP - 2);
  localparam logic [CNT_W-1:0] LD_WREC  = CNT_W'(BURST_LEN + T_WR - 2);
  localparam logic [CNT_W-1:0] LD_BURST = CNT_W'(BURST_LEN - 1);

  logic open_q;
  logic open_d;
  logic act_ev;
  logic pre_ev;
  logic rdap_ev;
  logic wr_ev;
  logic wrap_ev;
  logic rp_load;
  logic [CNT_W-1:0] rp_val;

  assign act_ev  = hit && (cmd == CMD_ACT);
  assign pre_ev  = (cmd == CMD_PRE) && (hit || a10) && open_q;
  assign rdap_ev = hit && (cmd == CMD_RD) && a10 && open_q;
  assign wr_ev   = hit && (cmd == CMD_WR) && open_q;
  assign wrap_ev = wr_ev && a10;

  always_comb begin
    open_d = open_q;
    if (act_ev) begin
      open_d = 1'b1;
    end else if (pre_ev || rdap_ev || wrap_ev) begin
      open_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
    end else begin
      open_q <= open_d;
    end
  end

  assign open_o = open_q;

  always_comb begin
    rp_load = 1'b1;
    rp_val  = LD_RP;
    if (rdap_ev) begin
      rp_val = LD_RDAP;
    end else if (wrap_ev) begin
      rp_val = LD_WRAP;
    end else if (!pre_ev) begin
      rp_load = 1'b0;
    end
  end

  sdrc_gap_timer #(.CNT_W(CNT_W)) u_rcd (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(act_ev),
    .load_val(LD_RCD), .busy(rcd_busy_o));

  sdrc_gap_timer #(.CNT_W(CNT_W)) u_ras (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(act_ev),
    .load_val(LD_RAS), .busy(ras_busy_o));

  sdrc_gap_timer #(.CNT_W(CNT_W)) u_rp (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(rp_load),
    .load_val(rp_val), .busy(rp_busy_o));

  sdrc_gap_timer #(.CNT_W(CNT_W)) u_wrec (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(wr_ev),
    .load_val(LD_WREC), .busy(wr_busy_o));

  sdrc_gap_timer #(.CNT_W(CNT_W)) u_apb (
    .clk(clk), .rst_n(rst_n), .adv(adv), .load(rdap_ev || wrap_ev),
    .load_val(LD_BURST), .busy(ap_busy_o));

  // R10: an activate leaves the bank open
  a_r10_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
    act_ev |=> open_o);

  // R2: a precharge reaching an open bank closes it
  a_r2_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
    pre_ev |=> !open_o);

  // R5: after an auto-precharge command the bank is idle and blocked
  a_r5_ap_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (rdap_ev || wrap_ev) |=> (!open_o && rp_busy_o));

endmodule

// File: rtl/sdram_rule_checker.sv
module sdram_rule_checker
  import sdrc_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned BURST_LEN = 4,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_RAS     = 6,
  parameter int unsigned T_RRD     = 2,
  parameter int unsigned T_WR      = 2,
  parameter int unsigned T_MRD     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mem_cke,
  input  logic                 mem_cs_n,
  input  logic                 mem_ras_n,
  input  logic                 mem_cas_n,
  input  logic                 mem_we_n,
  input  logic [BA_W-1:0]      mem_ba,
  input  logic                 mem_a10,
  input  logic                 clr_i,
  output logic [RULE_CNT-1:0]  viol_flags_o,
  output logic                 err_pulse_o,
  output logic [RULE_ID_W-1:0] err_id_o
);

  localparam int unsigned NUM_BANKS = 1 << BA_W;
  localparam int unsigned CNT_W =
    $clog2(BURST_LEN + T_WR + T_RP + T_RAS + T_RCD + T_RRD + T_MRD + 1);
  localparam logic [CNT_W-1:0] LD_RRD = CNT_W'(T_RRD - 1);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(T_MRD - 1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe_q[1];

  // clock enable as seen by the memory at the previous edge
  logic cke_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cke_q <= 1'b0;
    end else begin
      cke_q <= mem_cke;
    end
  end

  sdrc_cmd_e cmd;

  sdrc_decode u_decode (
    .adv(cke_q), .cs_n(mem_cs_n), .ras_n(mem_ras_n),
    .cas_n(mem_cas_n), .we_n(mem_we_n), .cmd(cmd));

  // per-bank state
  logic [NUM_BANKS-1:0] open_vec;
  logic [NUM_BANKS-1:0] rcd_vec;
  logic [NUM_BANKS-1:0] ras_vec;
  logic [NUM_BANKS-1:0] rp_vec;
  logic [NUM_BANKS-1:0] wr_vec;
  logic [NUM_BANKS-1:0] ap_vec;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdrc_bank #(
      .CNT_W(CNT_W), .BURST_LEN(BURST_LEN), .T_RCD(T_RCD),
      .T_RP(T_RP), .T_RAS(T_RAS), .T_WR(T_WR)
    ) u_bank (
      .clk(clk), .rst_n(rst_n_int), .adv(cke_q),
      .hit(mem_ba == BA_W'(b)), .a10(mem_a10), .cmd(cmd),
      .open_o(open_vec[b]), .rcd_busy_o(rcd_vec[b]),
      .ras_busy_o(ras_vec[b]), .rp_busy_o(rp_vec[b]),
      .wr_busy_o(wr_vec[b]), .ap_busy_o(ap_vec[b]));
  end

  // global windows
  logic rrd_busy;
  logic mrd_busy;

  sdrc_gap_timer #(.CNT_W(CNT_W)) u_rrd (
    .clk(clk), .rst_n(rst_n_int), .adv(cke_q), .load(cmd == CMD_ACT),
    .load_val(LD_RRD), .busy(rrd_busy));

  sdrc_gap_timer #(.CNT_W(CNT_W)) u_mrd (
    .clk(clk), .rst_n(rst_n_int), .adv(cke_q), .load(cmd == CMD_MRS),
    .load_val(LD_MRD), .busy(mrd_busy));

  // rule evaluation
  logic [RULE_CNT-1:0] viol;
  logic is_col;
  logic sel_open;

  assign is_col   = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign sel_open = open_vec[mem_ba];

  always_comb begin
    viol = '0;
    viol[RULE_MRD]      = (cmd != CMD_NOP) && mrd_busy;
    viol[RULE_OPENBUSY] = ((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|open_vec);
    viol[RULE_APBURST]  = is_col && (|ap_vec);
    viol[RULE_RP]       = (cmd == CMD_ACT) && rp_vec[mem_ba];
    viol[RULE_RRD]      = (cmd == CMD_ACT) && rrd_busy;
    viol[RULE_RCD]      = is_col && sel_open && rcd_vec[mem_ba];
    if (cmd == CMD_PRE) begin
      if (mem_a10) begin
        viol[RULE_RAS] = |(open_vec & ras_vec);
        viol[RULE_WR]  = |(open_vec & wr_vec);
      end else begin
        viol[RULE_RAS] = sel_open && ras_vec[mem_ba];
        viol[RULE_WR]  = sel_open && wr_vec[mem_ba];
      end
    end
    viol[RULE_IDLE]   = (is_col || ((cmd == CMD_PRE) && !mem_a10)) && !sel_open;
    viol[RULE_REOPEN] = (cmd == CMD_ACT) && sel_open;
  end

  // sticky flags
  logic [RULE_CNT-1:0] flags_q;
  logic [RULE_CNT-1:0] flags_d;

  always_comb begin
    flags_d = (clr_i ? '0 : flags_q) | viol;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign viol_flags_o = flags_q;
  assign err_pulse_o  = |viol;

  always_comb begin
    err_id_o = '0;
    for (int k = RULE_CNT - 1; k >= 0; k--) begin
      if (viol[k]) begin
        err_id_o = RULE_ID_W'(k + 1);
      end
    end
  end

  // R1: a no-operation never reports
  a_r1_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd == CMD_NOP) |-> !err_pulse_o);

  // R13: nothing is reported while the previous edge saw clock enable low
  a_r13_frozen_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!cke_q) |-> !err_pulse_o);

  // R3: mode set or refresh against an open bank is always reported
  a_r3_busy_mode: assert property (@(posedge clk) disable iff (!rst_n_int)
    (((cmd == CMD_MRS) || (cmd == CMD_REF)) && (|open_vec)) |-> err_pulse_o);

  // R11: without a clear no flag ever drops
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!clr_i) |=> ((viol_flags_o & $past(viol_flags_o)) == $past(viol_flags_o)));

  // R11: a clear with no violation empties the flags
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n_int)
    (clr_i && !err_pulse_o) |=> (viol_flags_o == '0));

  // R12: a pulse always leaves a flag behind and carries a non-zero id
  a_r12_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n_int)
    err_pulse_o |-> ((err_id_o != '0) ##1 (viol_flags_o != '0)));

endmodule

// File: tb/sdram_rule_checker_bench.sv
module sdram_rule_checker_bench;
  import sdrc_pkg::*;

  localparam logic [3:0] C_NOP   = 4'b0111;
  localparam logic [3:0] C_DESEL = 4'b1000;
  localparam logic [3:0] C_ACT   = 4'b0011;
  localparam logic [3:0] C_RD    = 4'b0101;
  localparam logic [3:0] C_WR    = 4'b0100;
  localparam logic [3:0] C_PRE   = 4'b0010;
  localparam logic [3:0] C_REF   = 4'b0001;
  localparam logic [3:0] C_MRS   = 4'b0000;

  logic clk;
  logic rst_n;
  logic mem_cke;
  logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
  logic [1:0] mem_ba;
  logic mem_a10;
  logic clr_i;
  logic [9:0] viol_flags_o;
  logic err_pulse_o;
  logic [3:0] err_id_o;

  int tests;
  int fails;
  logic [9:0] acc;

  int         q_id[$];
  logic [9:0] q_flags[$];
  string      q_tag[$];

  sdram_rule_checker #(
    .BA_W(2), .BURST_LEN(2), .T_RCD(2), .T_RP(3), .T_RAS(4),
    .T_RRD(2), .T_WR(2), .T_MRD(2)
  ) u_sdram_rule_checker (
    .clk(clk), .rst_n(rst_n), .mem_cke(mem_cke),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .mem_a10(mem_a10),
    .clr_i(clr_i), .viol_flags_o(viol_flags_o),
    .err_pulse_o(err_pulse_o), .err_id_o(err_id_o));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] bit_of(input int unsigned k);
    return 10'd1 << k;
  endfunction

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: one bus command per cycle, expected outcome into the scoreboard
  task automatic issue(input logic [3:0] code, input int bank, input logic a10,
                       input logic cke, input logic clr, input int exp_id,
                       input logic [9:0] mask, input string tag);
    @(negedge clk);
    {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = code;
    mem_ba  = 2'(bank);
    mem_a10 = a10;
    mem_cke = cke;
    clr_i   = clr;
    q_id.push_back(exp_id);
    q_flags.push_back(acc);
    q_tag.push_back(tag);
    acc = (clr ? 10'd0 : acc) | mask;
  endtask

  // monitor: compares just before the edge that ends each command cycle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q_id.size() > 0) begin
        int         e_id;
        logic [9:0] e_fl;
        string      e_tag;
        e_id  = q_id.pop_front();
        e_fl  = q_flags.pop_front();
        e_tag = q_tag.pop_front();
        check(e_tag, "err_id", int'(err_id_o), e_id);
        check(e_tag, "err_pulse", int'(err_pulse_o), int'(e_id != 0));
        check(e_tag, "flags", int'(viol_flags_o), int'(e_fl));
      end
    end
  end

  initial begin
    #(8 * 5000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0;
    fails = 0;
    acc   = '0;
    rst_n = 1'b0;
    mem_cke = 1'b1;
    {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = C_NOP;
    mem_ba = 2'd0;
    mem_a10 = 1'b0;
    clr_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 reset", "flags", int'(viol_flags_o), 0);
    check("R12 reset", "err_pulse", int'(err_pulse_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    issue(C_MRS,   0, 0, 1, 0, 0, '0, "R3 mode set with all idle");
    issue(C_DESEL, 0, 0, 1, 0, 0, '0, "R1 deselect inside mode gap");
    issue(C_ACT,   0, 0, 1, 0, 0, '0, "R4 command at mode gap end");
    issue(C_ACT,   1, 0, 1, 0, 5, bit_of(RULE_RRD), "R6 activate gap 1");
    issue(C_RD,    1, 0, 1, 0, 6, bit_of(RULE_RCD), "R7 read gap 1 after activate");
    issue(C_RD,    0, 0, 1, 0, 0, '0, "R7 read after activate window");
    issue(C_PRE,   1, 0, 1, 0, 7, bit_of(RULE_RAS), "R8 precharge gap 3 after activate");
    issue(C_ACT,   1, 0, 1, 0, 4, bit_of(RULE_RP), "R5 activate gap 1 after precharge");
    issue(C_ACT,   1, 0, 1, 0, 4,
          bit_of(RULE_RP) | bit_of(RULE_RRD) | bit_of(RULE_REOPEN),
          "R12 lowest rule wins");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 plain nop");
    issue(C_ACT,   1, 0, 1, 0, 10, bit_of(RULE_REOPEN), "R10 activate open bank");
    issue(C_RD,    2, 0, 1, 0, 9, bit_of(RULE_IDLE), "R9 read idle bank");
    issue(C_PRE,   3, 0, 1, 0, 9, bit_of(RULE_IDLE), "R9 precharge idle bank");
    issue(C_MRS,   0, 0, 1, 0, 2, bit_of(RULE_OPENBUSY), "R3 mode set with open bank");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R4 nop inside mode gap");
    issue(C_WR,    0, 0, 1, 0, 0, '0, "R4 write at mode gap end");
    issue(C_PRE,   0, 0, 1, 0, 8, bit_of(RULE_WR), "R8 precharge gap 1 after write");
    issue(C_PRE,   0, 1, 1, 0, 0, '0, "R2 precharge all closes bank 1");
    issue(C_PRE,   0, 1, 1, 0, 0, '0, "R9 precharge all with all idle");
    issue(C_REF,   0, 0, 1, 0, 0, '0, "R3 refresh with all idle");
    issue(C_MRS,   0, 0, 1, 0, 0, '0, "R3 mode set with all idle again");
    issue(C_REF,   0, 0, 1, 0, 1, bit_of(RULE_MRD), "R4 refresh gap 1 after mode set");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_ACT,   2, 0, 1, 0, 0, '0, "R2 activate bank 2");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_ACT,   3, 0, 1, 0, 0, '0, "R6 activate at spacing end");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_RD,    2, 1, 1, 0, 0, '0, "R5 read with auto precharge");
    issue(C_WR,    3, 0, 1, 0, 3, bit_of(RULE_APBURST), "R5 write inside auto precharge burst");
    issue(C_WR,    3, 0, 1, 0, 0, '0, "R5 write after burst end");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_ACT,   2, 0, 1, 0, 0, '0, "R5 activate at auto precharge recovery end");
    issue(C_NOP,   0, 0, 0, 0, 0, '0, "R13 clock enable drops");
    issue(C_RD,    1, 0, 0, 0, 0, '0, "R13 read ignored while frozen");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R13 still frozen");
    issue(C_RD,    1, 0, 1, 0, 9, bit_of(RULE_IDLE), "R13 checks resume");
    issue(C_RD,    3, 0, 1, 0, 0, '0, "R7 back-to-back read one");
    issue(C_RD,    2, 0, 1, 0, 0, '0, "R7 back-to-back read two");
    issue(C_WR,    3, 0, 1, 0, 0, '0, "R2 write bank 3");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R1 nop");
    issue(C_PRE,   3, 0, 1, 0, 0, '0, "R8 precharge at write recovery end");
    issue(C_NOP,   0, 0, 1, 1, 0, '0, "R11 clear all flags");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R11 flags empty after clear");
    issue(C_RD,    1, 0, 1, 1, 9, bit_of(RULE_IDLE), "R11 violation beats clear");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R11 flag kept");
    issue(C_NOP,   0, 0, 1, 0, 0, '0, "R11 flag still kept");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule